// File: doc/BRIEF.md
# Pixel-Clock Divider and Line Timer

This block runs entirely on an incoming pixel clock. It slows that clock down by a programmable power-of-two ratio into a one-cycle internal operation enable, and counts a programmable number of those enables to mark out each display line. Both settings arrive as packed fields of a timing control word. Codes that are not allowed stop the line timer and raise an error flag until a usable value is written.

Timing changes are staged. A new timing word is held in a pending copy and is moved into the live copy only when the current line wraps, so a running line is never shortened or stretched. When the line timer restarts after an error, it takes the pending copy at once.

Alongside the timer, the block samples an 18-bit pixel bus. A second control word selects the pixel-clock edge for sampling and the level of the enable input that admits data. Every admitted word is presented on the rising edge with a one-cycle valid strobe.

Top module: `pxclk_line_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `cfg_err` is 0, `cap_valid` is 0 and `clk_idx` is 0. The reset settings are divide-by-4, 16 internal clocks per line, rising-edge capture and low-active enable, so a line lasts 64 pixel clocks.
- R2: `op_ce` is high for exactly one pixel clock out of every 4, 8 or 16 when the timing word's divide code (bits 9:8) is 1, 2 or 3.
- R3: `clk_idx` advances by one after each `op_ce` and stays put otherwise. It runs from 0 to N-1 and then returns to 0, where N is the length code in bits 6:0 of the timing word. Every N from 16 to 127 is usable.
- R4: `line_start` is high for the whole first internal-clock period of each line (while `clk_idx` is 0), so it rises once every N×ratio pixel clocks.
- R5: A divide code of 0 or a length code below 16 sets `cfg_err` in the cycle after the write. While `cfg_err` is set, `op_ce` and `line_start` stay low and `clk_idx` is 0 from the second cycle on. After a valid write clears the flag, `line_start` goes high one pixel clock later with `clk_idx` at 0, and the new timing is used from that line on.
- R6: A valid timing write takes effect at the first line wrap that occurs after the write is registered. A write registered on the wrapping edge itself misses that wrap, so one more line runs with the old timing.
- R7: Bit 0 of the capture word selects the sampling edge: 0 samples on the rising pixel-clock edge, 1 on the falling edge. In both cases data is presented on the next rising edge.
- R8: Bit 1 of the capture word sets the enable level: 0 admits data only while `pix_en` is low, 1 only while it is high.
- R9: Bits 2 and 3 of the capture word are stored but change neither the capture behaviour nor the line timing.
- R10: `cap_valid` is high for one cycle for each admitted sample. When a sample is not admitted, `cap_valid` is 0 and `cap_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Incoming pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timing_wr | input | 1 | Writes the timing word from `cfg_wdata` |
| capture_wr | input | 1 | Writes the capture word from `cfg_wdata` |
| cfg_wdata | input | 16 | Control word data (timing: divide code 9:8, length 6:0; capture: edge 0, enable level 1, sync levels 3:2) |
| pix_en | input | 1 | Data enable pin |
| pix_data | input | 18 | Pixel data bus |
| op_ce | output | 1 | Internal operation clock enable, one pixel clock wide |
| line_start | output | 1 | High during the first internal clock of each line |
| clk_idx | output | 7 | Internal clock index within the current line |
| cap_data | output | 18 | Last admitted pixel word |
| cap_valid | output | 1 | One-cycle strobe for a newly admitted word |
| cfg_err | output | 1 | Pending timing word holds a code that is not allowed |

## Verification
The case most likely to go wrong is a timing write that lands on the same pixel-clock edge as the line wrap, because the staging copy and the live copy change on that edge. The bench places writes at a chosen offset from a detected `line_start` rise: mid-line, one edge before the wrapping edge, and exactly on it. It then measures the lengths of the next three lines in pixel clocks against the old and new N×ratio. A second overlap is an error write made while a line is running. Here the bench checks that `op_ce` and `line_start` stop in the cycle the flag rises, and that `clk_idx` is back to 0 by the next cycle.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int DIV_W    = 2;
  localparam int LEN_W    = 7;
  localparam int DIV_LSB  = 8;
  localparam int LEN_LSB  = 0;
  localparam int EDGE_BIT = 0;
  localparam int LVL_BIT  = 1;
  localparam int SYNC_LSB = 2;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [LEN_W-1:0] len;
  } line_cfg_t;

  function automatic logic cfg_ok(line_cfg_t c, int min_len);
    return (c.div != '0) && (int'(c.len) >= min_len);
  endfunction
endpackage

// File: rtl/lt_rst_sync.sv
module lt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh_q[g] <= 1'b0;
          else         sh_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh_q[g] <= 1'b0;
          else         sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/lt_divider.sv
module lt_divider
  import lt_pkg::*;
#(
  parameter int BASE_RATIO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);
  localparam int MAX_RATIO = (BASE_RATIO << ((1 << DIV_W) - 1)) >> 1;
  localparam int CNT_W     = $clog2(MAX_RATIO);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = CNT_W'(((BASE_RATIO << div_code) >> 1) - 1);
    tick = run && (cnt_q == last);
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lt_line_count.sv
module lt_line_count
  import lt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] idx,
  output logic             wrap
);
  logic [LEN_W-1:0] idx_d;

  always_comb begin
    wrap = tick && (idx == len - 1'b1);
    if (!run)      idx_d = '0;
    else if (wrap) idx_d = '0;
    else if (tick) idx_d = idx + 1'b1;
    else           idx_d = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_d;
  end
endmodule

// File: rtl/lt_capture.sv
module lt_capture #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_fall,
  input  logic              lvl_high,
  input  logic              pix_en,
  input  logic [DATA_W-1:0] pix_data,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_valid
);
  logic              admit;
  logic [DATA_W-1:0] neg_data_q;
  logic              neg_hit_q;
  logic [DATA_W-1:0] data_d;
  logic              valid_d;

  assign admit = lvl_high ? pix_en : ~pix_en;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_data_q <= '0;
      neg_hit_q  <= 1'b0;
    end else begin
      neg_hit_q <= admit;
      if (admit) neg_data_q <= pix_data;
    end
  end

  always_comb begin
    data_d  = cap_data;
    valid_d = 1'b0;
    if (on_fall) begin
      valid_d = neg_hit_q;
      if (neg_hit_q) data_d = neg_data_q;
    end else begin
      valid_d = admit;
      if (admit) data_d = pix_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data  <= '0;
      cap_valid <= 1'b0;
    end else begin
      cap_data  <= data_d;
      cap_valid <= valid_d;
    end
  end
endmodule

// File: rtl/pxclk_line_timer.sv
module pxclk_line_timer
  import lt_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int CFG_W       = 16,
  parameter int MIN_LEN     = 16,
  parameter int BASE_RATIO  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic              timing_wr,
  input  logic              capture_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              pix_en,
  input  logic [DATA_W-1:0] pix_data,
  output logic              op_ce,
  output logic              line_start,
  output logic [LEN_W-1:0]  clk_idx,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_valid,
  output logic              cfg_err
);
  localparam line_cfg_t RST_CFG = '{div: DIV_W'(1), len: LEN_W'(MIN_LEN)};

  logic      rst_sync_n;
  line_cfg_t pend_q, pend_d, live_q, live_d;
  logic      running_q, running_d;
  logic      fall_q, fall_d, lvl_q, lvl_d;
  logic [1:0] sync_lvl_unused_q, sync_lvl_unused_d;
  logic      run, line_wrap;
  logic      spare_bits_unused;

  assign spare_bits_unused = ^{cfg_wdata[CFG_W-1:DIV_LSB+DIV_W], cfg_wdata[LEN_LSB+LEN_W]};

  lt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (pix_clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign cfg_err = !cfg_ok(pend_q, MIN_LEN);
  assign run     = running_q && !cfg_err;

  always_comb begin
    pend_d            = pend_q;
    live_d            = live_q;
    fall_d            = fall_q;
    lvl_d             = lvl_q;
    sync_lvl_unused_d = sync_lvl_unused_q;
    running_d         = !cfg_err;
    if (timing_wr) begin
      pend_d.div = cfg_wdata[DIV_LSB +: DIV_W];
      pend_d.len = cfg_wdata[LEN_LSB +: LEN_W];
    end
    if (capture_wr) begin
      fall_d            = cfg_wdata[EDGE_BIT];
      lvl_d             = cfg_wdata[LVL_BIT];
      sync_lvl_unused_d = cfg_wdata[SYNC_LSB +: 2];
    end
    if (!running_q || line_wrap) live_d = pend_q;
  end

  always_ff @(posedge pix_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q            <= RST_CFG;
      live_q            <= RST_CFG;
      running_q         <= 1'b1;
      fall_q            <= 1'b0;
      lvl_q             <= 1'b0;
      sync_lvl_unused_q <= 2'b00;
    end else begin
      pend_q            <= pend_d;
      live_q            <= live_d;
      running_q         <= running_d;
      fall_q            <= fall_d;
      lvl_q             <= lvl_d;
      sync_lvl_unused_q <= sync_lvl_unused_d;
    end
  end

  lt_divider #(.BASE_RATIO(BASE_RATIO)) u_div (
    .clk      (pix_clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .div_code (live_q.div),
    .tick     (op_ce)
  );

  lt_line_count u_line (
    .clk   (pix_clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (op_ce),
    .len   (live_q.len),
    .idx   (clk_idx),
    .wrap  (line_wrap)
  );

  assign line_start = run && (clk_idx == '0);

  lt_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (pix_clk),
    .rst_n     (rst_sync_n),
    .on_fall   (fall_q),
    .lvl_high  (lvl_q),
    .pix_en    (pix_en),
    .pix_data  (pix_data),
    .cap_data  (cap_data),
    .cap_valid (cap_valid)
  );
endmodule

// File: rtl/pxclk_line_timer_chk.sv
module pxclk_line_timer_chk #(
  parameter int DATA_W = 18,
  parameter int LEN_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_ce,
  input logic              line_start,
  input logic [LEN_W-1:0]  clk_idx,
  input logic [LEN_W-1:0]  live_len,
  input logic              cfg_err,
  input logic              timing_wr,
  input logic [1:0]        wr_div,
  input logic              cap_valid,
  input logic [DATA_W-1:0] cap_data
);
  assert_ce_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_ce |=> !op_ce);

  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_ce |=> (clk_idx == $past(clk_idx) + 1'b1) || (clk_idx == '0));

  assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_ce && !cfg_err) |=> $stable(clk_idx));

  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_idx < live_len);

  assert_line_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && op_ce) |=> !line_start);

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!op_ce && !line_start));

  assert_err_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_wr && wr_div == 2'b00) |=> cfg_err);

  assert_cap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |-> $stable(cap_data));
endmodule

bind pxclk_line_timer pxclk_line_timer_chk #(.DATA_W(DATA_W), .LEN_W(lt_pkg::LEN_W)) u_chk (
  .clk        (pix_clk),
  .rst_n      (rst_sync_n),
  .op_ce      (op_ce),
  .line_start (line_start),
  .clk_idx    (clk_idx),
  .live_len   (live_q.len),
  .cfg_err    (cfg_err),
  .timing_wr  (timing_wr),
  .wr_div     (cfg_wdata[9:8]),
  .cap_valid  (cap_valid),
  .cap_data   (cap_data)
);

// File: tb/pxclk_line_timer_test.sv
`timescale 1ns/1ps
module pxclk_line_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        timing_wr = 1'b0;
  logic        capture_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        pix_en = 1'b1;
  logic [17:0] pix_data = '0;
  logic        op_ce, line_start, cap_valid, cfg_err;
  logic [6:0]  clk_idx;
  logic [17:0] cap_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pxclk_line_timer uut (
    .pix_clk(clk), .rst_n(rst_n), .timing_wr(timing_wr), .capture_wr(capture_wr),
    .cfg_wdata(cfg_wdata), .pix_en(pix_en), .pix_data(pix_data), .op_ce(op_ce),
    .line_start(line_start), .clk_idx(clk_idx), .cap_data(cap_data),
    .cap_valid(cap_valid), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_timing(input logic [15:0] w);
    timing_wr = 1'b1; cfg_wdata = w;
    tick();
    timing_wr = 1'b0;
  endtask

  task automatic wr_capture(input logic [15:0] w);
    capture_wr = 1'b1; cfg_wdata = w;
    tick();
    capture_wr = 1'b0;
  endtask

  // Runs until the next rise of line_start. Optionally drives a timing write
  // before the edge numbered wr_at+1 from the start sample.
  task automatic wait_line(input bit do_wr, input int wr_at, input logic [15:0] w,
                           output int n, output int opc, output int maxidx,
                           output int gmin, output int gmax);
    logic prev;
    int   last;
    prev = line_start; n = 0; opc = 0; maxidx = 0; gmin = 9999; gmax = 0; last = -1;
    forever begin
      if (do_wr && n == wr_at) begin timing_wr = 1'b1; cfg_wdata = w; end
      else timing_wr = 1'b0;
      tick();
      n++;
      if (op_ce) begin
        opc++;
        if (last >= 0) begin
          if (n - last < gmin) gmin = n - last;
          if (n - last > gmax) gmax = n - last;
        end
        last = n;
      end
      if (int'(clk_idx) > maxidx) maxidx = int'(clk_idx);
      if (line_start && !prev) break;
      prev = line_start;
      if (n > 5000) break;
    end
    timing_wr = 1'b0;
  endtask

  task automatic pix_step(input logic en, input logic [17:0] a, input logic [17:0] b);
    pix_en = en; pix_data = a;
    #2.5;
    pix_data = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1", "cfg_err in reset", int'(cfg_err), 0);
    check("R1", "cap_valid in reset", int'(cap_valid), 0);
    check("R1", "clk_idx in reset", int'(clk_idx), 0);
    rst_n = 1'b1;
    tick();
    check("R1", "cfg_err after release", int'(cfg_err), 0);
    check("R1", "clk_idx after release", int'(clk_idx), 0);
    check("R1", "cap_valid after release", int'(cap_valid), 0);
    repeat (3) tick();
    begin
      int n, opc, mx, gmin, gmax;
      wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
      wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
      check("R1", "default line length", n, 64);
      check("R2", "default op_ce gap", gmax, 4);
      check("R2", "default op_ce gap min", gmin, 4);
      check("R3", "default op_ce per line", opc, 16);
      check("R3", "default top index", mx, 15);
    end
  endtask

  task automatic t_ratio(input int code, input int len);
    int n, opc, mx, gmin, gmax, ratio;
    ratio = 4 << (code - 1);
    wait_line(1, 0, 16'((code << 8) | len), n, opc, mx, gmin, gmax);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    check("R4", "line rise spacing", n, ratio * len);
    check("R2", "op_ce gap max", gmax, ratio);
    check("R2", "op_ce gap min", gmin, ratio);
    check("R3", "op_ce per line", opc, len);
    check("R3", "top index", mx, len - 1);
  endtask

  task automatic t_boundary();
    int n, opc, mx, gmin, gmax;
    wr_timing(16'h0110);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    check("R6", "settled line", n, 64);
    wait_line(1, 20, 16'h0118, n, opc, mx, gmin, gmax);
    check("R6", "mid-line write keeps current", n, 64);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    check("R6", "mid-line write next line", n, 96);
    wait_line(1, 95, 16'h0110, n, opc, mx, gmin, gmax);
    check("R6", "write on wrap edge current", n, 96);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    check("R6", "write on wrap edge misses boundary", n, 96);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    check("R6", "write on wrap edge applied after", n, 64);
    wait_line(1, 62, 16'h0114, n, opc, mx, gmin, gmax);
    check("R6", "write one before wrap current", n, 64);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    check("R6", "write one before wrap applied", n, 80);
  endtask

  task automatic t_err();
    int n, opc, mx, gmin, gmax, bad_ce, bad_ls, bad_idx;
    wr_timing(16'h0110);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    repeat (9) tick();
    wr_timing(16'h0010);
    check("R5", "flag after div code 0", int'(cfg_err), 1);
    check("R5", "op_ce in flag cycle", int'(op_ce), 0);
    bad_ce = 0; bad_ls = 0; bad_idx = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (op_ce) bad_ce++;
      if (line_start) bad_ls++;
      if (clk_idx != 0) bad_idx++;
    end
    check("R5", "op_ce while stopped", bad_ce, 0);
    check("R5", "line_start while stopped", bad_ls, 0);
    check("R5", "clk_idx while stopped", bad_idx, 0);
    wr_timing(16'h010F);
    check("R5", "flag with length 15", int'(cfg_err), 1);
    repeat (5) tick();
    wr_timing(16'h0110);
    check("R5", "flag cleared", int'(cfg_err), 0);
    check("R5", "no line_start on clear cycle", int'(line_start), 0);
    tick();
    check("R5", "line_start on restart", int'(line_start), 1);
    check("R5", "index on restart", int'(clk_idx), 0);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    check("R5", "first line after restart", n, 64);
  endtask

  task automatic t_capture();
    wr_capture(16'h0000);
    pix_step(1'b0, 18'h0AAAA, 18'h15555);
    check("R7", "rising edge valid", int'(cap_valid), 1);
    check("R7", "rising edge data", int'(cap_data), 'h15555);
    pix_step(1'b1, 18'h01234, 18'h04321);
    check("R10", "low-level enable blocks valid", int'(cap_valid), 0);
    check("R10", "low-level enable holds data", int'(cap_data), 'h15555);
    wr_capture(16'h0001);
    pix_step(1'b0, 18'h2BEEF, 18'h1CAFE);
    check("R7", "falling edge valid", int'(cap_valid), 1);
    check("R7", "falling edge data", int'(cap_data), 'h2BEEF);
    pix_step(1'b1, 18'h00F0F, 18'h0F0F0);
    check("R10", "falling edge blocked valid", int'(cap_valid), 0);
    check("R10", "falling edge blocked hold", int'(cap_data), 'h2BEEF);
    wr_capture(16'h0002);
    pix_step(1'b1, 18'h00111, 18'h00222);
    check("R8", "high-level enable valid", int'(cap_valid), 1);
    check("R8", "high-level enable data", int'(cap_data), 'h00222);
    pix_step(1'b0, 18'h00333, 18'h00444);
    check("R8", "high-level enable blocks", int'(cap_valid), 0);
    check("R8", "high-level enable hold", int'(cap_data), 'h00222);
    wr_capture(16'h0003);
    pix_step(1'b1, 18'h00555, 18'h00666);
    check("R8", "falling high-level data", int'(cap_data), 'h00555);
    pix_step(1'b0, 18'h00777, 18'h00888);
    check("R10", "falling high-level blocked", int'(cap_valid), 0);
    pix_en = 1'b0;
    tick();
    check("R10", "valid is a single-cycle pulse", int'(cap_valid), 0);
  endtask

  task automatic t_sync_bits();
    int n, opc, mx, gmin, gmax;
    wr_capture(16'h000C);
    pix_step(1'b0, 18'h01010, 18'h02020);
    check("R9", "sync bits keep rising low-level", int'(cap_data), 'h02020);
    pix_step(1'b1, 18'h03030, 18'h04040);
    check("R9", "sync bits keep enable level", int'(cap_valid), 0);
    wr_capture(16'h000D);
    pix_step(1'b0, 18'h05050, 18'h06060);
    check("R9", "sync bits keep falling edge", int'(cap_data), 'h05050);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    wait_line(0, 0, 16'h0, n, opc, mx, gmin, gmax);
    check("R9", "sync bits keep line length", n, 64);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    t_ratio(2, 20);
    t_ratio(3, 127);
    t_ratio(1, 127);
    t_ratio(1, 16);
    t_boundary();
    t_err();
    t_capture();
    t_sync_bits();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1-watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule